// File: doc/BRIEF.md
# Leftmost-Zero Dispatch Adder

This block is the execution unit for a priority-dispatch instruction. It takes an 8-bit value from the input bus and a 16-bit destination register value. It finds the most significant bit of the byte that is zero and turns that position into an even addend between 0 and 14. It adds that addend to the destination value. The sum is registered on an execute strobe and presented one clock later with a one-cycle valid pulse, so the register file can write it back.

When the destination is the program counter, the instruction becomes an eight-way computed jump. Each table slot is two bytes apart, and the slot is chosen by which input flag is the first one found clear. Register storage and instruction decode sit outside this block. It receives a destination-is-PC flag only so that it can report that flag alongside the result.

Top module: `zero_dispatch_adder`

## Requirements
- R1: While reset is asserted and right after it is released, `result_o` is 0 and `result_vld_o`, `no_zero_o` and `pc_dispatch_o` are all 0.
- R2: Bus bits are numbered by position k, where k=0 is `bus_i[7]` (the most significant bit) and k=7 is `bus_i[0]`. If the lowest-numbered zero is at position k, the addend is 2·k. Bits at positions after that zero have no effect.
- R3: If all eight bus bits are one, the addend is 0 and `no_zero_o` is 1. If any bus bit is zero, `no_zero_o` is 0.
- R4: The sum is `dest_i` plus the addend, taken modulo 65536. There is no carry output.
- R5: `exec_i` high at a rising clock edge makes the new result and status visible after that edge, with `result_vld_o` high for exactly that one cycle. Strobes on consecutive cycles give valid on consecutive cycles, each cycle showing its own result.
- R6: When `exec_i` is low, `result_o`, `no_zero_o` and `pc_dispatch_o` keep their values, whatever `bus_i`, `dest_i` and `dest_is_pc_i` do.
- R7: `pc_dispatch_o` shows the value `dest_is_pc_i` had at the strobe that produced the result currently shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe |
| bus_i | input | 8 | Input bus byte searched for its leftmost zero |
| dest_i | input | 16 | Current destination register value |
| dest_is_pc_i | input | 1 | Destination is the program counter |
| result_o | output | 16 | Registered destination plus addend |
| result_vld_o | output | 1 | One-cycle pulse when a new result is shown |
| no_zero_o | output | 1 | The captured bus byte had no zero bit |
| pc_dispatch_o | output | 1 | The captured instruction targeted the program counter |

## Verification
The hardest case to reach is proving that the bits after the leftmost zero are ignored. Any byte that has a given zero position can also carry arbitrary bits to its right. The stimulus therefore sweeps every zero position twice: once with all trailing bits one and once with all trailing bits zero, and expects the same addend both times. Wraparound is reached by loading a destination near 0xFFFF with a large addend. Hold behaviour is shown by changing every input while the strobe is low and observing that the outputs do not move.

// File: rtl/zdisp_pkg.sv
package zdisp_pkg;
  parameter int unsigned BUS_W  = 8;
  parameter int unsigned DATA_W = 16;
  localparam int unsigned IDX_W = $clog2(BUS_W);
  localparam int unsigned ADD_W = IDX_W + 1;

  typedef logic [BUS_W-1:0]  bus_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [ADD_W-1:0]  addend_t;
endpackage

// File: rtl/zdisp_zero_finder.sv
module zdisp_zero_finder
  import zdisp_pkg::*;
(
  input  bus_t bus_i,
  output idx_t pos_o,
  output logic found_o
);
  logic [BUS_W-1:0] above_ones;
  logic [BUS_W-1:0] sel;

  genvar gi;
  generate
    for (gi = BUS_W - 1; gi >= 0; gi--) begin : g_bit
      if (gi == BUS_W - 1) begin : g_top
        assign above_ones[gi] = 1'b1;
      end else begin : g_rest
        assign above_ones[gi] = above_ones[gi+1] & bus_i[gi+1];
      end
      assign sel[gi] = above_ones[gi] & ~bus_i[gi];
    end
  endgenerate

  always_comb begin
    pos_o = '0;
    for (int i = 0; i < BUS_W; i++) begin
      if (sel[i]) pos_o = pos_o | idx_t'(BUS_W - 1 - i);
    end
  end

  assign found_o = |sel;

  // R2
  always_comb begin
    onehot_sel_chk: assert ($onehot0(sel));
  end
endmodule

// File: rtl/zdisp_addend.sv
module zdisp_addend
  import zdisp_pkg::*;
(
  input  idx_t    pos_i,
  input  logic    found_i,
  output addend_t addend_o
);
  always_comb begin
    if (found_i) addend_o = {pos_i, 1'b0};
    else         addend_o = '0;
  end
endmodule

// File: rtl/zdisp_wrap_adder.sv
module zdisp_wrap_adder
  import zdisp_pkg::*;
(
  input  data_t   a_i,
  input  addend_t b_i,
  output data_t   sum_o
);
  assign sum_o = a_i + data_t'(b_i);
endmodule

// File: rtl/zero_dispatch_adder.sv
module zero_dispatch_adder
  import zdisp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec_i,
  input  logic [7:0]  bus_i,
  input  logic [15:0] dest_i,
  input  logic        dest_is_pc_i,
  output logic [15:0] result_o,
  output logic        result_vld_o,
  output logic        no_zero_o,
  output logic        pc_dispatch_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  idx_t    zpos;
  logic    zfound;
  addend_t addend;
  data_t   sum;

  zdisp_zero_finder u_find (.bus_i(bus_i), .pos_o(zpos), .found_o(zfound));
  zdisp_addend      u_addn (.pos_i(zpos), .found_i(zfound), .addend_o(addend));
  zdisp_wrap_adder  u_add  (.a_i(dest_i), .b_i(addend), .sum_o(sum));

  data_t res_d, res_q;
  logic  vld_d, vld_q, nz_d, nz_q, pc_d, pc_q;

  always_comb begin
    res_d = res_q;
    nz_d  = nz_q;
    pc_d  = pc_q;
    vld_d = exec_i;
    if (exec_i) begin
      res_d = sum;
      nz_d  = ~zfound;
      pc_d  = dest_is_pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      nz_q  <= 1'b0;
      pc_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      nz_q  <= nz_d;
      pc_q  <= pc_d;
    end
  end

  assign result_o      = res_q;
  assign result_vld_o  = vld_q;
  assign no_zero_o     = nz_q;
  assign pc_dispatch_o = pc_q;

  // R5
  valid_follows_exec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_i |=> result_vld_o);
  // R5
  valid_only_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_i |=> !result_vld_o);
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_i |=> ($stable(result_o) && $stable(no_zero_o) && $stable(pc_dispatch_o)));
  // R3
  all_ones_no_add_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && (&bus_i)) |=> (no_zero_o && result_o == $past(dest_i)));
  // R7
  pc_flag_tracks_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_i |=> (pc_dispatch_o == $past(dest_is_pc_i)));
endmodule

// File: tb/sim_zero_dispatch_adder.sv
module sim_zero_dispatch_adder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_i;
  logic [7:0]  bus_i;
  logic [15:0] dest_i;
  logic        dest_is_pc_i;
  logic [15:0] result_o;
  logic        result_vld_o, no_zero_o, pc_dispatch_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_dispatch_adder u0 (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .bus_i(bus_i), .dest_i(dest_i),
    .dest_is_pc_i(dest_is_pc_i), .result_o(result_o), .result_vld_o(result_vld_o),
    .no_zero_o(no_zero_o), .pc_dispatch_o(pc_dispatch_o));

  function automatic logic [15:0] exp_addend(input logic [7:0] b);
    for (int k = 0; k < 8; k++) if (!b[7-k]) return 16'(2*k);
    return 16'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, strobe captured at next posedge, observed at following negedge
  task automatic apply(input logic [7:0] b, input logic [15:0] d, input logic pc, input string req);
    exec_i = 1'b1; bus_i = b; dest_i = d; dest_is_pc_i = pc;
    @(negedge clk);
    exec_i = 1'b0;
    chk(req, "result", result_o, d + exp_addend(b));
    chk(req, "valid", 16'(result_vld_o), 16'd1);
    chk(req, "no_zero", 16'(no_zero_o), 16'(&b));
    chk(req, "pc flag", 16'(pc_dispatch_o), 16'(pc));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; exec_i = 1'b0; bus_i = 8'h00; dest_i = 16'h1234; dest_is_pc_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "result in reset", result_o, 16'h0);
    chk("R1", "valid in reset", 16'(result_vld_o), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "result after reset", result_o, 16'h0);
    chk("R1", "flags after reset", 16'({result_vld_o, no_zero_o, pc_dispatch_o}), 16'h0);
  endtask

  task automatic t_positions();
    for (int k = 0; k < 8; k++) begin
      logic [7:0] ones_tail, zero_tail;
      ones_tail = 8'hFF & ~(8'h80 >> k);
      zero_tail = 8'hFF << (8 - k);
      apply(ones_tail, 16'h1000, 1'b0, "R2");
      chk("R2", "addend ones tail", result_o, 16'h1000 + 16'(2*k));
      apply(zero_tail, 16'h2000, 1'b0, "R2");
      chk("R2", "addend zero tail", result_o, 16'h2000 + 16'(2*k));
    end
  endtask

  task automatic t_all_ones();
    apply(8'hFF, 16'hABCD, 1'b0, "R3");
    chk("R3", "no_zero set", 16'(no_zero_o), 16'd1);
    apply(8'hFE, 16'h0000, 1'b0, "R3");
    chk("R3", "no_zero clear", 16'(no_zero_o), 16'd0);
  endtask

  task automatic t_wrap();
    apply(8'hFE, 16'hFFF8, 1'b0, "R4");
    chk("R4", "wrap sum", result_o, 16'h0006);
    apply(8'h00, 16'hFFFF, 1'b0, "R4");
    chk("R4", "no add at bit 0", result_o, 16'hFFFF);
  endtask

  task automatic t_back_to_back();
    exec_i = 1'b1; bus_i = 8'hDF; dest_i = 16'h0100; dest_is_pc_i = 1'b0;
    @(negedge clk);
    chk("R5", "first result", result_o, 16'h0104);
    chk("R5", "first valid", 16'(result_vld_o), 16'd1);
    bus_i = 8'hF7; dest_i = 16'h0200;
    @(negedge clk);
    exec_i = 1'b0;
    chk("R5", "second result", result_o, 16'h0208);
    chk("R5", "second valid", 16'(result_vld_o), 16'd1);
    @(negedge clk);
    chk("R5", "valid drops", 16'(result_vld_o), 16'd0);
  endtask

  task automatic t_hold();
    apply(8'h7F, 16'h4242, 1'b1, "R6");
    bus_i = 8'hFF; dest_i = 16'h9999; dest_is_pc_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6", "result held", result_o, 16'h4242);
    chk("R6", "flags held", 16'({no_zero_o, pc_dispatch_o}), 16'b01);
    chk("R6", "no valid", 16'(result_vld_o), 16'd0);
  endtask

  task automatic t_pc();
    apply(8'hEF, 16'h0800, 1'b1, "R7");
    chk("R7", "pc dispatch set", 16'(pc_dispatch_o), 16'd1);
    apply(8'hEF, 16'h0800, 1'b0, "R7");
    chk("R7", "pc dispatch clear", 16'(pc_dispatch_o), 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_positions();
    t_all_ones();
    t_wrap();
    t_back_to_back();
    t_hold();
    t_pc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule